// File: doc/BRIEF.md
# Shift-Mask Interpolator Lane Pair

This block is a register-mapped arithmetic helper. It holds two 32-bit accumulators, three base registers and two lane control words. Each lane picks an accumulator, shifts it right, keeps a chosen bit window and can sign-extend that window. It then adds its base value to form the lane result. A third result adds the third base to the window outputs of both lanes. Software walks through tables or fixed-point ramps by reading results and adding to the accumulators.

Reads use a simple strobe interface with separate read and write addresses. A read from a PEEK address returns a result and changes nothing. A read from a POP address returns the same result and also loads both accumulators from the lane results in the same clock. A write to an add address increments an accumulator by a 24-bit amount in one update. Read-only overflow flags in the control words show when bits outside a lane's window are set.

Address map (rd_addr_i / wr_addr_i): 0 ACC0, 1 ACC1, 2 BASE0, 3 BASE1, 4 BASE2, 5 POP0, 6 POP1, 7 POP2, 8 PEEK0, 9 PEEK1, 10 PEEK2, 11 CTRL0, 12 CTRL1, 13 ADD0, 14 ADD1. Any other read address returns 0.

Control word fields:

| Bits | Field |
|---|---|
| 4:0 | right-shift amount |
| 6:5 | force value |
| 12:8 | window low bit |
| 20:16 | window high bit |
| 24 | sign extend |
| 25 | cross input |
| 26 | cross result |
| 27 | raw add (lane 0 only; reads 0 in CTRL1) |
| 29 | overflow of accumulator 0 (read-only) |
| 30 | overflow of accumulator 1 (read-only) |
| 31 | OR of bits 29 and 30 (read-only) |

The read-only bits 29 to 31 show the same values in both control words.

Top module: `interp_pair`

## Requirements
- R1: The window output of a lane is its input accumulator shifted right logically by bits 4:0. Every bit below the low bit (12:8) and above the high bit (20:16) is then cleared. If the low bit is greater than the high bit, the window output is 0.
- R2: When the sign-extend bit 24 is set, every bit above the high bit is filled with the window output's bit at the high-bit position.
- R3: When the cross-input bit 25 is set, the lane uses the other lane's accumulator as its input.
- R4: A read of POP0, POP1 or POP2 returns the result of that address. At the same clock edge, each accumulator is loaded with its own lane's result. If that lane's cross-result bit 26 is set, it is loaded with the other lane's result instead. The force value never reaches an accumulator.
- R5: A read of PEEK0, PEEK1 or PEEK2 returns the same value as the matching POP address and leaves the accumulators, bases and controls unchanged.
- R6: When bit 27 is set in CTRL0, lane 0 adds its unshifted, unmasked input to the base in place of the window output. The bit has no effect on lane 1 or on the third result, and CTRL1 always reads it as 0.
- R7: The 2-bit force value of a lane is ORed into bits 29:28 of that lane's result on the bus. The third result has no force value.
- R8: Bit 29 of a control word reads 1 when accumulator 0, shifted by lane 0's shift amount, has any set bit outside lane 0's window. Bit 30 does the same for accumulator 1 with lane 1's settings. Bit 31 is the OR of bits 29 and 30.
- R9: A write to ADD0 or ADD1 adds wdata_i[23:0], zero-extended, to that accumulator in a single clock, with 32-bit wrap-around. An add takes priority over a POP load of the same accumulator.
- R10: The lane 0 result is BASE0 plus the lane 0 output, and the lane 1 result is BASE1 plus the lane 1 output. The third result is BASE2 plus both window outputs. All sums wrap at 32 bits.
- R11: Accumulators and bases can be written and read directly. A direct write to an accumulator takes priority over a POP in the same cycle, while the other accumulator still takes its POP value.
- R12: After reset, all accumulators, bases and control fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Write address |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe; a read of a POP address takes effect at the next clock edge |
| rd_addr_i | input | 4 | Read address |
| rdata_o | output | 32 | Read data, combinational from the read address |

## Verification
The bench sets a window whose low bit is above its high bit, expecting an empty output. A design without that check would pass stray bits through. It also tests sign fill from a high bit of 7, 32-bit wrap-around in the lane and third sums, and raw add set in both control words. A design that leaked raw add into lane 1 or into the third result would return the full accumulator there. POP tests cover the cross-result path and a force value that must stay out of the accumulator. A POP that collides with a direct write checks that the write wins on one accumulator while the other still takes its POP value. Overflow flags are read in both the set and the clear case for each accumulator.

// File: rtl/interp_pkg.sv
package interp_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SH_W   = $clog2(DATA_W);
  localparam int unsigned ADR_W  = 4;

  typedef enum logic [ADR_W-1:0] {
    A_ACC0  = 4'd0,  A_ACC1  = 4'd1,
    A_BASE0 = 4'd2,  A_BASE1 = 4'd3,  A_BASE2 = 4'd4,
    A_POP0  = 4'd5,  A_POP1  = 4'd6,  A_POP2  = 4'd7,
    A_PEEK0 = 4'd8,  A_PEEK1 = 4'd9,  A_PEEK2 = 4'd10,
    A_CTRL0 = 4'd11, A_CTRL1 = 4'd12,
    A_ADD0  = 4'd13, A_ADD1  = 4'd14
  } addr_e;

  typedef struct packed {
    logic [SH_W-1:0] shift;
    logic [SH_W-1:0] lo;
    logic [SH_W-1:0] hi;
    logic            sext;
    logic            x_in;
    logic            x_res;
    logic            raw;
    logic [1:0]      frc;
  } lane_cfg_t;

  function automatic logic [DATA_W-1:0] cfg_to_word(lane_cfg_t c);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[4:0]   = c.shift;
    w[6:5]   = c.frc;
    w[12:8]  = c.lo;
    w[20:16] = c.hi;
    w[24]    = c.sext;
    w[25]    = c.x_in;
    w[26]    = c.x_res;
    w[27]    = c.raw;
    return w;
  endfunction
endpackage

// File: rtl/interp_lane.sv
module interp_lane
  import interp_pkg::*;
#(
  parameter bit HAS_RAW = 1'b0
) (
  input  logic [DATA_W-1:0] own_acc_i,
  input  logic [DATA_W-1:0] other_acc_i,
  input  logic [DATA_W-1:0] base_i,
  input  lane_cfg_t         cfg_i,
  output logic [DATA_W-1:0] shaped_o,
  output logic [DATA_W-1:0] result_o,
  output logic              overf_o
);
  logic [DATA_W-1:0] ones, sel, shifted, mask, masked, hi_fill, own_sh, addend;
  logic [SH_W-1:0]   top_gap;
  logic              use_raw;

  assign ones    = '1;
  assign top_gap = SH_W'(DATA_W - 1) - cfg_i.hi;

  always_comb begin
    sel      = cfg_i.x_in ? other_acc_i : own_acc_i;
    shifted  = sel >> cfg_i.shift;
    mask     = (ones << cfg_i.lo) & (ones >> top_gap);
    masked   = shifted & mask;
    hi_fill  = ~(ones >> top_gap);
    shaped_o = (cfg_i.sext && masked[cfg_i.hi]) ? (masked | hi_fill) : masked;
    own_sh   = own_acc_i >> cfg_i.shift;
    overf_o  = |(own_sh & ~mask);
  end

  generate
    if (HAS_RAW) begin : g_raw
      assign use_raw = cfg_i.raw;
    end else begin : g_noraw
      assign use_raw = 1'b0;
    end
  endgenerate

  assign addend   = use_raw ? sel : shaped_o;
  assign result_o = base_i + addend;
endmodule

// File: rtl/interp_acc.sv
module interp_acc
  import interp_pkg::*;
#(
  parameter int unsigned ADD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              add_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] pop_val_i,
  output logic [DATA_W-1:0] acc_o
);
  logic [DATA_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (wr_i)  acc_q <= wdata_i;
    else if (add_i) acc_q <= acc_q + DATA_W'(wdata_i[ADD_W-1:0]);
    else if (pop_i) acc_q <= pop_val_i;
  end

  assign acc_o = acc_q;

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !add_i && !pop_i) |=> $stable(acc_q));

  p_add_sum_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !wr_i) |=> acc_q == $past(acc_q) + DATA_W'($past(wdata_i[ADD_W-1:0])));

  p_write_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> acc_q == $past(wdata_i));

  p_pop_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !wr_i && !add_i) |=> acc_q == $past(pop_val_i));
endmodule

// File: rtl/interp_pair.sv
module interp_pair
  import interp_pkg::*;
#(
  parameter int unsigned ADD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic [ADR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned FRC_POS = DATA_W - 4;
  localparam int unsigned OV0_BIT = DATA_W - 3;
  localparam int unsigned OV1_BIT = DATA_W - 2;
  localparam int unsigned OVA_BIT = DATA_W - 1;

  logic [DATA_W-1:0] base_q [3];
  lane_cfg_t         cfg_q  [2];
  lane_cfg_t         wcfg;
  logic [DATA_W-1:0] acc    [2];
  logic [DATA_W-1:0] shaped [2];
  logic [DATA_W-1:0] res    [2];
  logic [DATA_W-1:0] bus_res[2];
  logic [DATA_W-1:0] pop_val[2];
  logic [DATA_W-1:0] res2, ctrl_flags;
  logic [1:0]        overf;
  logic              pop, peek;

  always_comb begin
    wcfg.shift = wdata_i[4:0];
    wcfg.frc   = wdata_i[6:5];
    wcfg.lo    = wdata_i[12:8];
    wcfg.hi    = wdata_i[20:16];
    wcfg.sext  = wdata_i[24];
    wcfg.x_in  = wdata_i[25];
    wcfg.x_res = wdata_i[26];
    wcfg.raw   = wdata_i[27];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '{default: '0};
      cfg_q  <= '{default: '0};
    end else if (wr_en_i) begin
      case (addr_e'(wr_addr_i))
        A_BASE0: base_q[0] <= wdata_i;
        A_BASE1: base_q[1] <= wdata_i;
        A_BASE2: base_q[2] <= wdata_i;
        A_CTRL0: cfg_q[0]  <= wcfg;
        A_CTRL1: cfg_q[1]  <= '{shift: wcfg.shift, lo: wcfg.lo, hi: wcfg.hi,
                                sext: wcfg.sext, x_in: wcfg.x_in, x_res: wcfg.x_res,
                                raw: 1'b0, frc: wcfg.frc};
        default: ;
      endcase
    end
  end

  assign pop  = rd_en_i && (rd_addr_i == A_POP0 || rd_addr_i == A_POP1 || rd_addr_i == A_POP2);
  assign peek = rd_en_i && (rd_addr_i == A_PEEK0 || rd_addr_i == A_PEEK1 || rd_addr_i == A_PEEK2);

  for (genvar i = 0; i < 2; i++) begin : g_lane
    localparam addr_e ACC_A = (i == 0) ? A_ACC0 : A_ACC1;
    localparam addr_e ADD_A = (i == 0) ? A_ADD0 : A_ADD1;

    interp_lane #(.HAS_RAW(i == 0)) i_lane (
      .own_acc_i  (acc[i]),
      .other_acc_i(acc[1-i]),
      .base_i     (base_q[i]),
      .cfg_i      (cfg_q[i]),
      .shaped_o   (shaped[i]),
      .result_o   (res[i]),
      .overf_o    (overf[i])
    );

    assign pop_val[i] = cfg_q[i].x_res ? res[1-i] : res[i];
    assign bus_res[i] = res[i] | (DATA_W'(cfg_q[i].frc) << FRC_POS);

    interp_acc #(.ADD_W(ADD_W)) i_acc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_en_i && wr_addr_i == ACC_A),
      .add_i    (wr_en_i && wr_addr_i == ADD_A),
      .pop_i    (pop),
      .wdata_i  (wdata_i),
      .pop_val_i(pop_val[i]),
      .acc_o    (acc[i])
    );
  end

  assign res2 = base_q[2] + shaped[0] + shaped[1];

  always_comb begin
    ctrl_flags          = '0;
    ctrl_flags[OV0_BIT] = overf[0];
    ctrl_flags[OV1_BIT] = overf[1];
    ctrl_flags[OVA_BIT] = |overf;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_e'(rd_addr_i))
        A_ACC0:           rdata_o = acc[0];
        A_ACC1:           rdata_o = acc[1];
        A_BASE0:          rdata_o = base_q[0];
        A_BASE1:          rdata_o = base_q[1];
        A_BASE2:          rdata_o = base_q[2];
        A_POP0, A_PEEK0:  rdata_o = bus_res[0];
        A_POP1, A_PEEK1:  rdata_o = bus_res[1];
        A_POP2, A_PEEK2:  rdata_o = res2;
        A_CTRL0:          rdata_o = cfg_to_word(cfg_q[0]) | ctrl_flags;
        A_CTRL1:          rdata_o = cfg_to_word(cfg_q[1]) | ctrl_flags;
        default:          rdata_o = '0;
      endcase
    end
  end

  p_peek_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peek && !wr_en_i) |=> $stable(acc[0]) && $stable(acc[1]));

  p_pop_moves_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !wr_en_i && !cfg_q[1].x_res) |=> acc[1] == $past(res[1]));
endmodule

// File: tb/test_interp_pair.sv
module test_interp_pair;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  int total = 0, bad = 0;

  always #2 clk_i = ~clk_i;

  interp_pair i_interp_pair (.*);

  function automatic logic [31:0] mkc(int sh, int lo, int hi, bit sx = 0, bit xi = 0,
                                      bit xr = 0, bit rw = 0, int fr = 0);
    return 32'(sh) | (32'(fr) << 5) | (32'(lo) << 8) | (32'(hi) << 16) |
           (32'(sx) << 24) | (32'(xi) << 25) | (32'(xr) << 26) | (32'(rw) << 27);
  endfunction

  typedef struct packed {
    logic [31:0] c0, c1, a0, a1, b0, b1, b2, e0, e1, e2;
  } vec_t;

  // R1 R10 plain, R1 shifted windows, R2 sign fill, R3 cross input,
  // R6 raw add, R7 force, R1 empty window with R10 wrap
  localparam vec_t VECS [7] = '{
    '{mkc(0,0,31), mkc(0,0,31), 32'h12345678, 32'h10, 0, 0, 0,
      32'h12345678, 32'h10, 32'h12345688},
    '{mkc(4,0,7), mkc(8,4,11), 32'h12345678, 32'hABCDEF01, 32'h100, 32'h5, 32'h1000,
      32'h167, 32'hDE5, 32'h1E47},
    '{mkc(0,0,7,1), mkc(0,0,7,1), 32'hF0, 32'h7F, 32'h20, 0, 0,
      32'h10, 32'h7F, 32'h6F},
    '{mkc(0,0,31,0,1), mkc(0,0,31,0,1), 32'hAAAA0000, 32'h5555, 0, 0, 0,
      32'h5555, 32'hAAAA0000, 32'hAAAA5555},
    '{mkc(8,0,3,0,0,0,1), mkc(8,0,3,0,0,0,1), 32'h1234, 32'h1234, 1, 1, 0,
      32'h1235, 32'h3, 32'h4},
    '{mkc(0,0,31,0,0,0,0,3), mkc(0,0,31,0,0,0,0,1), 1, 2, 0, 0, 0,
      32'h30000001, 32'h10000002, 32'h3},
    '{mkc(0,8,4), mkc(0,31,31), 32'hFF, 32'h80000000, 7, 32'h80000000, 1,
      32'h7, 32'h0, 32'h80000001}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    rd_en_i = 1'b1; rd_addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    rd_chk("R12 acc0", 4'd0, 0);
    rd_chk("R12 acc1", 4'd1, 0);
    rd_chk("R12 base2", 4'd4, 0);
    rd_chk("R12 ctrl0", 4'd11, 0);

    for (int v = 0; v < 7; v++) begin
      wr(4'd11, VECS[v].c0); wr(4'd12, VECS[v].c1);
      wr(4'd0, VECS[v].a0);  wr(4'd1, VECS[v].a1);
      wr(4'd2, VECS[v].b0);  wr(4'd3, VECS[v].b1); wr(4'd4, VECS[v].b2);
      rd(4'd8, d);  chk($sformatf("R10 peek0 vec%0d", v), d, VECS[v].e0);
      rd(4'd9, d);  chk($sformatf("R10 peek1 vec%0d", v), d, VECS[v].e1);
      rd(4'd10, d); chk($sformatf("R10 peek2 vec%0d", v), d, VECS[v].e2);
    end

    // R5: PEEK reads of the last vector left both accumulators alone
    rd_chk("R5 acc0 kept", 4'd0, 32'hFF);
    rd_chk("R5 acc1 kept", 4'd1, 32'h80000000);

    // R4: POP loads both accumulators
    wr(4'd11, mkc(0,0,31)); wr(4'd12, mkc(0,0,31));
    wr(4'd0, 5); wr(4'd1, 7); wr(4'd2, 1); wr(4'd3, 2); wr(4'd4, 0);
    rd_chk("R4 pop0 value", 4'd5, 6);
    rd_chk("R4 acc0 after pop", 4'd0, 6);
    rd_chk("R4 acc1 after pop", 4'd1, 9);
    rd_chk("R4 pop2 value", 4'd7, 15);
    rd_chk("R4 acc0 after pop2", 4'd0, 7);
    rd_chk("R4 acc1 after pop2", 4'd1, 11);

    // R4: cross result feeds lane 1 result into accumulator 0
    wr(4'd11, mkc(0,0,31,0,0,1));
    rd_chk("R4 pop1 value", 4'd6, 13);
    rd_chk("R4 cross acc0", 4'd0, 13);
    rd_chk("R4 cross acc1", 4'd1, 13);

    // R7: force bits on the bus only
    wr(4'd11, mkc(0,0,31,0,0,0,0,3)); wr(4'd0, 0); wr(4'd2, 4);
    rd_chk("R7 pop0 forced", 4'd5, 32'h30000004);
    rd_chk("R7 acc0 unforced", 4'd0, 4);

    // R9: add with wrap, upper write bits dropped
    wr(4'd0, 32'hFFFFFFF0); wr(4'd13, 32'hFF000020);
    rd_chk("R9 add0 wrap", 4'd0, 32'h10);
    wr(4'd1, 32'h100); wr(4'd14, 32'h00FFFFFF);
    rd_chk("R9 add1", 4'd1, 32'h010000FF);

    // R11: direct write beats POP on acc0, acc1 still pops
    wr(4'd11, mkc(0,0,31)); wr(4'd12, mkc(0,0,31));
    wr(4'd2, 1); wr(4'd3, 3); wr(4'd0, 32'h10); wr(4'd1, 32'h100);
    wr_en_i = 1'b1; wr_addr_i = 4'd0; wdata_i = 32'hDEAD;
    rd_en_i = 1'b1; rd_addr_i = 4'd5;
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    rd_chk("R11 acc0 write wins", 4'd0, 32'hDEAD);
    rd_chk("R11 acc1 popped", 4'd1, 32'h103);

    // R8: overflow flags
    wr(4'd11, mkc(0,0,7)); wr(4'd0, 32'h100); wr(4'd1, 5);
    rd_chk("R8 ctrl0 ovf0", 4'd11, mkc(0,0,7) | (32'd1 << 29) | (32'd1 << 31));
    rd_chk("R8 ctrl1 ovf0", 4'd12, mkc(0,0,31) | (32'd1 << 29) | (32'd1 << 31));
    wr(4'd0, 32'h80);
    rd_chk("R8 ctrl0 clear", 4'd11, mkc(0,0,7));
    wr(4'd12, mkc(0,0,3)); wr(4'd1, 32'h10);
    rd_chk("R8 ctrl1 ovf1", 4'd12, mkc(0,0,3) | (32'd1 << 30) | (32'd1 << 31));

    // R6: raw bit not kept in lane 1 control
    wr(4'd12, mkc(0,0,31,0,0,0,1));
    rd_chk("R6 ctrl1 raw reads 0", 4'd12, mkc(0,0,31));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule